// File: doc/BRIEF.md
# Power-Switchover Timestamp Capture

This block keeps two snapshots of the calendar time that mark supply changes. When the system moves from main supply to battery, the current time and date are latched into a power-loss bank. When it returns to main supply, they are latched into a power-restore bank. The two banks follow opposite retention rules. The power-loss bank keeps the earliest event and ignores later ones until software clears it. The power-restore bank is replaced by every new restore event.

The supply source arrives as a single, clean, asynchronous "on battery" level. The block synchronises it and turns each transition into a one-cycle capture strobe. Software reads both banks as flat 64-bit words. It writes them one byte field at a time through a small write port. It can also empty the power-loss bank in one step with a clear-all strobe.

Top module: `pwr_tstamp`

## Requirements
- R1: A low-to-high change of `on_batt` copies `live_time` into `loss_time` when the power-loss bank is armed. The two synchroniser stages and one edge-detect register place the new value on `loss_time` after the third rising clock edge following the change.
- R2: Once the power-loss bank has captured, later low-to-high changes of `on_batt` leave `loss_time` unchanged until the bank is re-armed. Writes that leave any byte of the bank non-zero do not re-arm it.
- R3: A high-to-low change of `on_batt` copies `live_time` into `restore_time`, with the same three-edge latency as R1.
- R4: Every high-to-low change of `on_batt` overwrites `restore_time`, whatever the bank held before.
- R5: A one-cycle `clr_all` pulse sets `loss_time` to zero and re-arms the power-loss bank.
- R6: With `wr_en` high, `wr_bank`=0 selects the power-loss bank and `wr_bank`=1 selects the power-restore bank. `wr_idx` selects field i at bits [8i+7:8i], where 0=tenths, 1=seconds, 2=minutes, 3=hours, 4=day of week, 5=date, 6=month and 7=year, all in BCD. `wr_data` replaces that field on the next edge. A write that leaves all eight power-loss fields at 00h re-arms that bank.
- R7: The power-restore bank reads zero after 00h has been written to each of its eight fields.
- R8: When a capture occurs in the same cycle as a write or a `clr_all` on the same bank, the capture wins and the bank holds `live_time`.
- R9: After reset both banks read zero and the power-loss bank is armed. The synchroniser resets to "main supply".
- R10: Each transition of `on_batt` causes exactly one capture. Changes of `live_time` after the capture do not alter either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_batt | input | 1 | Asynchronous supply-source level, 1 = running on battery |
| live_time | input | 64 | Current calendar time, eight BCD byte fields |
| wr_en | input | 1 | Field write strobe |
| wr_bank | input | 1 | Write target: 0 power-loss, 1 power-restore |
| wr_idx | input | 3 | Field index of the write |
| wr_data | input | 8 | Field write value |
| clr_all | input | 1 | One-cycle clear and re-arm of the power-loss bank |
| loss_time | output | 64 | Power-loss snapshot |
| restore_time | output | 64 | Power-restore snapshot |

## Verification
Several rules are checked on every cycle. A rising strobe on an armed bank must load the live time. A bank that holds a capture and sees no write or clear must keep its contents. Every falling strobe must load the restore bank. A clear must empty the loss bank. A write must land in the addressed field. Each strobe must last a single cycle. Other behaviour shows only in the bench scenarios that run from the `on_batt` pin. These cover the exact three-edge latency, first-event retention across repeated power cycles, and re-arming once all fields are zeroed by writes. They also cover capture winning over a write or clear issued on the very capture edge, and bank contents staying fixed while the live time keeps moving.

// File: rtl/pts_pkg.sv
package pts_pkg;
    localparam int FIELDS  = 8;
    localparam int FIELD_W = 8;
    localparam int IDX_W   = $clog2(FIELDS);
    localparam int STAMP_W = FIELDS * FIELD_W;

    typedef logic [FIELD_W-1:0] field_t;
    typedef field_t [FIELDS-1:0] stamp_t;
endpackage

// File: rtl/pts_sync.sv
module pts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pts_edge.sv
module pts_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/pts_bank.sv
module pts_bank
    import pts_pkg::*;
#(
    parameter bit KEEP_FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  field_t           wr_data,
    input  stamp_t           live,
    output stamp_t           snap,
    output logic             held
);
    typedef struct packed {
        stamp_t regs;
        logic   held;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     fire;

    generate
        if (KEEP_FIRST) begin : g_first
            assign fire = cap & ~st_q.held;
        end else begin : g_latest
            assign fire = cap;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.regs = live;
            st_d.held = KEEP_FIRST;
        end else if (clr) begin
            st_d.regs = '0;
            st_d.held = 1'b0;
        end else if (wr_en) begin
            st_d.regs[wr_idx] = wr_data;
            st_d.held = st_q.held && (st_d.regs != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap = st_q.regs;
    assign held = st_q.held;
endmodule

// File: rtl/pwr_tstamp.sv
module pwr_tstamp #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         on_batt,
    input  logic [pts_pkg::STAMP_W-1:0]  live_time,
    input  logic                         wr_en,
    input  logic                         wr_bank,
    input  logic [pts_pkg::IDX_W-1:0]    wr_idx,
    input  logic [pts_pkg::FIELD_W-1:0]  wr_data,
    input  logic                         clr_all,
    output logic [pts_pkg::STAMP_W-1:0]  loss_time,
    output logic [pts_pkg::STAMP_W-1:0]  restore_time
);
    import pts_pkg::*;

    logic   batt_s, batt_rise, batt_fall;
    logic   loss_held, rest_held;
    stamp_t loss_snap, rest_snap;

    pts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (on_batt),
        .sync_out (batt_s)
    );

    pts_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (batt_s),
        .rise  (batt_rise),
        .fall  (batt_fall)
    );

    pts_bank #(.KEEP_FIRST(1'b1)) u_loss (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (batt_rise),
        .clr     (clr_all),
        .wr_en   (wr_en & ~wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .live    (live_time),
        .snap    (loss_snap),
        .held    (loss_held)
    );

    pts_bank #(.KEEP_FIRST(1'b0)) u_rest (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (batt_fall),
        .clr     (1'b0),
        .wr_en   (wr_en & wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .live    (live_time),
        .snap    (rest_snap),
        .held    (rest_held)
    );

    assign loss_time    = loss_snap;
    assign restore_time = rest_snap;
endmodule

// File: rtl/pts_checker.sv
module pts_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] live_time,
    input logic        wr_en,
    input logic        wr_bank,
    input logic [2:0]  wr_idx,
    input logic [7:0]  wr_data,
    input logic        clr_all,
    input logic        batt_rise,
    input logic        batt_fall,
    input logic        loss_held,
    input logic        rest_held,
    input logic [63:0] loss_time,
    input logic [63:0] restore_time
);
    a_r1_loss_capture: assert property (@(posedge clk) disable iff (!rst_n)
        batt_rise && !loss_held |=> loss_time == $past(live_time));

    a_r2_loss_retained: assert property (@(posedge clk) disable iff (!rst_n)
        loss_held && !clr_all && !wr_en |=> $stable(loss_time));

    a_r3_restore_capture: assert property (@(posedge clk) disable iff (!rst_n)
        batt_fall |=> restore_time == $past(live_time));

    a_r4_restore_never_locks: assert property (@(posedge clk) disable iff (!rst_n)
        !rest_held);

    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all && !(batt_rise && !loss_held) |=> loss_time == '0 && !loss_held);

    a_r6_field_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_bank && !clr_all && !(batt_rise && !loss_held)
        |=> loss_time[$past(wr_idx)*8 +: 8] == $past(wr_data));

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_rise || batt_fall) |=> !(batt_rise || batt_fall));
endmodule

bind pwr_tstamp pts_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .live_time    (live_time),
    .wr_en        (wr_en),
    .wr_bank      (wr_bank),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .clr_all      (clr_all),
    .batt_rise    (batt_rise),
    .batt_fall    (batt_fall),
    .loss_held    (loss_held),
    .rest_held    (rest_held),
    .loss_time    (loss_time),
    .restore_time (restore_time)
);

// File: tb/sim_pwr_tstamp.sv
module sim_pwr_tstamp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        on_batt = 1'b0;
    logic [63:0] live_time = '0;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        clr_all = 1'b0;
    logic [63:0] loss_time, restore_time;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwr_tstamp u0 (
        .clk(clk), .rst_n(rst_n), .on_batt(on_batt), .live_time(live_time),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
        .clr_all(clr_all), .loss_time(loss_time), .restore_time(restore_time)
    );

    function automatic logic [7:0] bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic logic [63:0] tval(int n);
        return {bcd((n * 3) % 100), bcd(n % 12 + 1), bcd(n % 28 + 1), bcd(n % 7 + 1),
                bcd((n * 5) % 24), bcd((n * 13) % 60), bcd((n * 7) % 60), bcd(n % 10)};
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic bank, int idx, logic [7:0] data);
        wr_en = 1'b1; wr_bank = bank; wr_idx = 3'(idx); wr_data = data;
        step(1);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] pat;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R9 loss reset", loss_time, '0);
        chk("R9 restore reset", restore_time, '0);

        // R1 first capture, R2 retention, R3/R4 restore overwrite, R10 single capture
        for (int k = 0; k < 5; k++) begin
            live_time = tval(k + 1);
            on_batt = 1'b1;
            step(5);
            chk(k == 0 ? "R1 loss capture" : "R2 loss keeps first", loss_time, tval(1));
            live_time = tval(k + 20);
            on_batt = 1'b0;
            step(5);
            chk(k == 0 ? "R3 restore capture" : "R4 restore overwrite", restore_time, tval(k + 20));
            live_time = tval(k + 50);
            step(3);
            chk("R10 restore fixed after capture", restore_time, tval(k + 20));
            chk("R10 loss fixed after capture", loss_time, tval(1));
        end

        // R5 clear-all and re-arm
        clr_all = 1'b1; step(1); clr_all = 1'b0;
        chk("R5 clear-all zeroes loss", loss_time, '0);
        live_time = tval(60);
        on_batt = 1'b1; step(5);
        chk("R5 re-armed capture", loss_time, tval(60));
        on_batt = 1'b0; step(5);

        // R6 field writes, bank still held while non-zero
        pat = '0;
        for (int i = 0; i < 8; i++) begin
            wr(1'b0, i, 8'(8'h11 * (i + 1)));
            pat[i*8 +: 8] = 8'(8'h11 * (i + 1));
        end
        chk("R6 field write mapping", loss_time, pat);
        live_time = tval(65);
        on_batt = 1'b1; step(5);
        chk("R2 non-zero writes keep bank locked", loss_time, pat);
        on_batt = 1'b0; step(5);
        chk("R4 restore after locked loss", restore_time, tval(65));

        // R7 restore cleared by writes
        for (int i = 0; i < 8; i++) wr(1'b1, i, 8'h00);
        chk("R7 restore zero by writes", restore_time, '0);

        // R6 zeroing all loss fields re-arms
        for (int i = 0; i < 8; i++) wr(1'b0, i, 8'h00);
        chk("R6 loss zero by writes", loss_time, '0);
        live_time = tval(70);
        on_batt = 1'b1; step(5);
        chk("R6 re-armed after zero writes", loss_time, tval(70));

        // R8 capture beats a write on the restore bank
        live_time = tval(80);
        on_batt = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr_en = 1'b1; wr_bank = 1'b1; wr_idx = 3'd2; wr_data = 8'h99;
        step(1);
        wr_en = 1'b0;
        step(3);
        chk("R8 capture beats restore write", restore_time, tval(80));

        // R8 capture beats clear-all on the loss bank
        clr_all = 1'b1; step(1); clr_all = 1'b0;
        live_time = tval(90);
        on_batt = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        clr_all = 1'b1;
        step(1);
        clr_all = 1'b0;
        step(3);
        chk("R8 capture beats clear-all", loss_time, tval(90));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule